// File: doc/BRIEF.md
# Receive Packet FIFO with Status Prefix and CRC Rollback

This block is a shared receive buffer for a full-speed device controller. Each incoming packet is stored as one status word followed by its payload words, 32 bits at a time. The receive engine opens a packet with a start pulse and then streams payload words. It closes the packet with an end pulse that carries the CRC verdict, the byte count and a transfer-complete flag. Until that end pulse every write is tentative. A good CRC commits the whole packet to the reader in one step. A bad CRC returns the write pointer to the packet's first slot, so the reader never sees any part of that packet.

A packet is refused when it starts if the free space is smaller than one status word plus the worst-case payload. The refusal raises `no_space` for one cycle so that the endpoint logic can answer with a NAK. Software then takes packets out one at a time. It pops a status word first, and the read side uses that word's byte count to know how many payload words follow. A flush input clears the buffer in one cycle and abandons any packet that is being written.

The write controller has two states. `W_IDLE` goes to `W_OPEN` on an accepted start. A refused start, `wr_start` with too little free space, stays in `W_IDLE`. `W_OPEN` goes back to `W_IDLE` on a good end (commit), on a bad end (rollback) or on a flush. The read controller also has two states. `R_HEAD` means the next word is a status word. Popping a status word with a nonzero byte count goes to `R_BODY`. Popping the last payload word returns to `R_HEAD`. A flush forces `R_HEAD`.

Top module: `rxpkt_fifo`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_sop` is 1 and `no_space` is 0.
- R2: After a good end, the reader sees a status word and then ceil(bytes/4) payload words in the order they were written. The status word is laid out as follows:
  - [3:0] endpoint number
  - [14:4] byte count
  - [16:15] data PID
  - [20:17] status code
  - [31:21] zero
- R3: A packet that ends with `end_crc_ok`=0 leaves nothing readable, and the space it used is returned. A later good packet reads back intact.
- R4: A start with free words < 1 + ceil(MPS/4) is refused: `no_space` is 1 in the next cycle. The data and end of the refused packet write nothing. A start with exactly that many free words is accepted.
- R5: Words of a packet that has not yet ended are not visible: `rd_valid` stays 0 while only open-packet words are stored.
- R6: `rd_sop` is 1 exactly when the head word is a status word. A packet with a byte count of 0 is one status word with no payload.
- R7: Payload words beyond ceil(MPS/4) in one packet are dropped.
- R8: `flush` empties the buffer in one cycle and aborts an open packet. A later end for that packet commits nothing.
- R9: `rd_pop` while `rd_valid` is 0 has no effect.
- R10: The status code is 3 (transfer complete) when `end_xfer_done` is 1 at the end pulse, and 2 (data received) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the buffer and abort an open packet |
| wr_start | input | 1 | Open a new packet |
| wr_ep | input | 4 | Endpoint number, sampled at start |
| wr_pid | input | 2 | Data PID, sampled at start |
| wr_valid | input | 1 | Payload word present |
| wr_data | input | 32 | Payload word |
| wr_end | input | 1 | Close the open packet (carries no data) |
| end_crc_ok | input | 1 | 1 = CRC good, commit; 0 = roll back |
| end_xfer_done | input | 1 | Selects status code 3 instead of 2 |
| end_bytes | input | 11 | Byte count of the packet |
| no_space | output | 1 | One-cycle pulse after a refused start |
| rd_pop | input | 1 | Remove the head word |
| rd_valid | output | 1 | A committed word is available |
| rd_sop | output | 1 | Head word is a status word |
| rd_data | output | 32 | Head word |

## Verification
The bench fills the buffer until exactly 1 + ceil(MPS/4) words are free and checks that the next start is accepted and the one after it is refused. A design with an off-by-one in the space check would refuse the first start or accept the second, and would then overwrite unread data.

Bad-CRC packets are placed between good ones. A design that failed to roll back would show stray payload words before the next status word. A design that committed early would show `rd_valid` during an open packet.

The bench also covers several edge cases. It sends a zero-byte packet, an over-long packet, a flush in the middle of a packet followed by a late end pulse, and a pop on an empty buffer. These catch a read side that loses its packet framing, and a write side that keeps a packet open after a flush.

// File: rtl/rxpkt_pkg.sv
package rxpkt_pkg;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_OPEN = 1'b1
    } wr_state_t;

    typedef enum logic {
        R_HEAD = 1'b0,
        R_BODY = 1'b1
    } rd_state_t;

    localparam logic [3:0] STS_DATA = 4'd2;
    localparam logic [3:0] STS_DONE = 4'd3;

    function automatic logic [31:0] pack_status(
        input logic [3:0]  ep,
        input logic [10:0] bytes,
        input logic [1:0]  pid,
        input logic [3:0]  code
    );
        return {11'd0, code, pid, bytes, ep};
    endfunction

endpackage

// File: rtl/rxpkt_mem.sv
module rxpkt_mem #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/rxpkt_wr_ctrl.sv
module rxpkt_wr_ctrl
    import rxpkt_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int MPS_BYTES = 64,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1,
    localparam int MAXW     = (MPS_BYTES + 3) / 4,
    localparam int NEED     = MAXW + 1,
    localparam int NW       = $clog2(MAXW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_start,
    input  logic [3:0]    wr_ep,
    input  logic [1:0]    wr_pid,
    input  logic          wr_valid,
    input  logic [31:0]   wr_data,
    input  logic          wr_end,
    input  logic          end_crc_ok,
    input  logic          end_xfer_done,
    input  logic [10:0]   end_bytes,
    input  logic [PW-1:0] rptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [31:0]   mem_wdata,
    output logic [PW-1:0] cptr,
    output logic          no_space
);

    wr_state_t     state_q, state_d;
    logic [PW-1:0] wptr;
    logic [3:0]    ep_q;
    logic [1:0]    pid_q;
    logic [NW-1:0] nwords;
    logic [PW:0]   used, free_words;
    logic          room, take_word, good_end, bad_end, accept, refuse;

    assign used       = {1'b0, cptr - rptr};
    assign free_words = (PW+1)'(DEPTH) - used;
    assign room       = free_words >= (PW+1)'(NEED);

    assign accept    = (state_q == W_IDLE) && wr_start && room;
    assign refuse    = (state_q == W_IDLE) && wr_start && !room;
    assign good_end  = (state_q == W_OPEN) && wr_end && end_crc_ok;
    assign bad_end   = (state_q == W_OPEN) && wr_end && !end_crc_ok;
    assign take_word = (state_q == W_OPEN) && !wr_end && wr_valid
                       && (nwords < NW'(MAXW));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: if (accept) state_d = W_OPEN;
            W_OPEN: if (wr_end) state_d = W_IDLE;
        endcase
        if (flush) state_d = W_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // pointers and latched header fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            cptr     <= '0;
            ep_q     <= '0;
            pid_q    <= '0;
            nwords   <= '0;
            no_space <= 1'b0;
        end else if (flush) begin
            wptr     <= '0;
            cptr     <= '0;
            nwords   <= '0;
            no_space <= 1'b0;
        end else begin
            no_space <= refuse;
            if (accept) begin
                wptr   <= cptr + PW'(1);
                ep_q   <= wr_ep;
                pid_q  <= wr_pid;
                nwords <= '0;
            end
            if (take_word) begin
                wptr   <= wptr + PW'(1);
                nwords <= nwords + NW'(1);
            end
            if (good_end) cptr <= wptr;
            if (bad_end)  wptr <= cptr;
        end
    end

    // memory write port: payload at wptr, status into the reserved slot at cptr
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = wptr[AW-1:0];
        mem_wdata = wr_data;
        if (!flush) begin
            if (take_word) begin
                mem_we = 1'b1;
            end else if (good_end) begin
                mem_we    = 1'b1;
                mem_waddr = cptr[AW-1:0];
                mem_wdata = pack_status(ep_q, end_bytes, pid_q,
                                        end_xfer_done ? STS_DONE : STS_DATA);
            end
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        used <= (PW+1)'(DEPTH));

    p_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refuse && !flush) |=> (no_space && state_q == W_IDLE && $stable(wptr)));

    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (good_end && !flush) |=> (cptr == $past(wptr)));

    p_rollback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_end && !flush) |=> ($stable(cptr) && wptr == cptr));

    p_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_OPEN && !wr_end && !flush) |=> $stable(cptr));

    p_maxlen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nwords <= NW'(MAXW));

    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cptr == '0 && wptr == '0 && state_q == W_IDLE));

endmodule

// File: rtl/rxpkt_rd_ctrl.sv
module rxpkt_rd_ctrl
    import rxpkt_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int LW   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          rd_pop,
    input  logic [PW-1:0] cptr,
    input  logic [10:0]   head_bytes,
    output logic [PW-1:0] rptr,
    output logic          rd_valid,
    output logic          rd_sop
);

    rd_state_t     state_q, state_d;
    logic [LW-1:0] left;
    logic [LW-1:0] head_words;
    logic          pop;

    assign rd_valid   = (cptr != rptr);
    assign pop        = rd_pop && rd_valid;
    assign head_words = LW'((12'(head_bytes) + 12'd3) >> 2);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_HEAD: if (pop && head_words != '0) state_d = R_BODY;
            R_BODY: if (pop && left == LW'(1))   state_d = R_HEAD;
        endcase
        if (flush) state_d = R_HEAD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= R_HEAD;
        else        state_q <= state_d;
    end

    // read pointer and payload countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr <= '0;
            left <= '0;
        end else if (flush) begin
            rptr <= '0;
            left <= '0;
        end else if (pop) begin
            rptr <= rptr + PW'(1);
            if (state_q == R_HEAD) left <= head_words;
            else                   left <= left - LW'(1);
        end
    end

    // outputs
    always_comb begin
        rd_sop = (state_q == R_HEAD);
    end

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !rd_valid && !flush) |=> ($stable(rptr) && $stable(state_q)));

    p_body_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_BODY && pop && left == LW'(1) && !flush) |=> rd_sop);

    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_HEAD && pop && head_words == '0 && !flush) |=> rd_sop);

endmodule

// File: rtl/rxpkt_fifo.sv
module rxpkt_fifo
    import rxpkt_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int MPS_BYTES = 64,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        wr_start,
    input  logic [3:0]  wr_ep,
    input  logic [1:0]  wr_pid,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        wr_end,
    input  logic        end_crc_ok,
    input  logic        end_xfer_done,
    input  logic [10:0] end_bytes,
    output logic        no_space,
    input  logic        rd_pop,
    output logic        rd_valid,
    output logic        rd_sop,
    output logic [31:0] rd_data
);

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [31:0]   mem_wdata;
    logic [PW-1:0] cptr, rptr;

    rxpkt_wr_ctrl #(.DEPTH(DEPTH), .MPS_BYTES(MPS_BYTES)) wr_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_start(wr_start), .wr_ep(wr_ep), .wr_pid(wr_pid),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_end(wr_end),
        .end_crc_ok(end_crc_ok), .end_xfer_done(end_xfer_done),
        .end_bytes(end_bytes), .rptr(rptr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .cptr(cptr), .no_space(no_space)
    );

    rxpkt_mem #(.DEPTH(DEPTH), .WIDTH(32)) mem_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rptr[AW-1:0]), .rdata(rd_data)
    );

    rxpkt_rd_ctrl #(.DEPTH(DEPTH)) rd_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rd_pop(rd_pop),
        .cptr(cptr), .head_bytes(rd_data[14:4]),
        .rptr(rptr), .rd_valid(rd_valid), .rd_sop(rd_sop)
    );

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rd_valid);

endmodule

// File: tb/rxpkt_fifo_tb_top.sv
module rxpkt_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        wr_start = 1'b0;
    logic [3:0]  wr_ep = '0;
    logic [1:0]  wr_pid = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_end = 1'b0;
    logic        end_crc_ok = 1'b0;
    logic        end_xfer_done = 1'b0;
    logic [10:0] end_bytes = '0;
    logic        no_space;
    logic        rd_pop = 1'b0;
    logic        rd_valid;
    logic        rd_sop;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rxpkt_fifo dut_i (.*);

    // {ep[4], pid[2], bytes[11], crc_ok[1], xfer_done[1]}
    localparam int NVEC = 6;
    localparam logic [18:0] VEC [NVEC] = '{
        {4'd1,  2'd0, 11'd13, 1'b1, 1'b0},
        {4'd2,  2'd2, 11'd64, 1'b1, 1'b1},
        {4'd3,  2'd1, 11'd7,  1'b0, 1'b0},
        {4'd4,  2'd3, 11'd0,  1'b1, 1'b1},
        {4'd15, 2'd0, 11'd1,  1'b1, 1'b0},
        {4'd5,  2'd2, 11'd20, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pay(input logic [3:0] ep, input int j);
        return 32'hD000_0000 | (32'(ep) << 16) | 32'(j);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [3:0] ep, input logic [1:0] pid, input logic [10:0] bytes,
                        input logic ok, input logic xd, input int nw);
        wr_start = 1'b1; wr_ep = ep; wr_pid = pid;
        tick();
        wr_start = 1'b0;
        for (int j = 0; j < nw; j++) begin
            wr_valid = 1'b1; wr_data = pay(ep, j);
            tick();
        end
        wr_valid = 1'b0;
        wr_end = 1'b1; end_crc_ok = ok; end_xfer_done = xd; end_bytes = bytes;
        tick();
        wr_end = 1'b0;
    endtask

    task automatic pop1();
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic recv(input string req, input logic [3:0] ep, input logic [1:0] pid,
                        input logic [10:0] bytes, input logic xd);
        int nw = (int'(bytes) + 3) / 4;
        chk(req, {31'd0, rd_valid}, 32'd1);
        chk("R6", {31'd0, rd_sop}, 32'd1);
        chk(xd ? "R10" : req, rd_data,
            {11'd0, (xd ? 4'd3 : 4'd2), pid, bytes, ep});
        pop1();
        for (int j = 0; j < nw; j++) begin
            chk("R6", {31'd0, rd_sop}, 32'd0);
            chk(req, rd_data, pay(ep, j));
            pop1();
        end
        chk("R6", {31'd0, rd_sop}, 32'd1);
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1", {31'd0, rd_valid}, 32'd0);
        chk("R1", {31'd0, rd_sop}, 32'd1);
        chk("R1", {31'd0, no_space}, 32'd0);
        rst_n = 1'b1;
        tick();

        // vector table: R2 good packets, R3 rollback, R10 status code
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  ep = VEC[v][18:15];
            logic [1:0]  pid = VEC[v][14:13];
            logic [10:0] by = VEC[v][12:2];
            logic        ok = VEC[v][1];
            logic        xd = VEC[v][0];
            send(ep, pid, by, ok, xd, (int'(by) + 3) / 4);
            if (ok) recv("R2", ep, pid, by, xd);
            else    chk("R3", {31'd0, rd_valid}, 32'd0);
        end

        // R3: bad packet between good ones leaves no stray words
        send(4'd6, 2'd0, 11'd8, 1'b1, 1'b0, 2);
        send(4'd7, 2'd1, 11'd16, 1'b0, 1'b0, 4);
        send(4'd8, 2'd2, 11'd4, 1'b1, 1'b1, 1);
        recv("R3", 4'd6, 2'd0, 11'd8, 1'b0);
        recv("R3", 4'd8, 2'd2, 11'd4, 1'b1);
        chk("R3", {31'd0, rd_valid}, 32'd0);

        // R5: open packet is hidden
        wr_start = 1'b1; wr_ep = 4'd9; wr_pid = 2'd0;
        tick();
        wr_start = 1'b0;
        for (int j = 0; j < 3; j++) begin
            wr_valid = 1'b1; wr_data = pay(4'd9, j);
            tick();
        end
        wr_valid = 1'b0;
        tick();
        chk("R5", {31'd0, rd_valid}, 32'd0);
        wr_end = 1'b1; end_crc_ok = 1'b1; end_xfer_done = 1'b0; end_bytes = 11'd12;
        tick();
        wr_end = 1'b0;
        recv("R5", 4'd9, 2'd0, 11'd12, 1'b0);

        // R7: over-long packet truncated to 16 words
        send(4'd10, 2'd1, 11'd64, 1'b1, 1'b0, 20);
        recv("R7", 4'd10, 2'd1, 11'd64, 1'b0);
        chk("R7", {31'd0, rd_valid}, 32'd0);

        // R9: pop on empty has no effect
        pop1();
        chk("R9", {31'd0, rd_valid}, 32'd0);
        chk("R9", {31'd0, rd_sop}, 32'd1);
        send(4'd11, 2'd0, 11'd4, 1'b1, 1'b0, 1);
        recv("R9", 4'd11, 2'd0, 11'd4, 1'b0);

        // R4: fill to the boundary (6x17 + 9 = 111 used, 17 free)
        for (int k = 0; k < 6; k++) send(4'd12, 2'd0, 11'd64, 1'b1, 1'b0, 16);
        send(4'd12, 2'd0, 11'd32, 1'b1, 1'b0, 8);
        wr_start = 1'b1; wr_ep = 4'd13; wr_pid = 2'd1;
        tick();
        wr_start = 1'b0;
        chk("R4", {31'd0, no_space}, 32'd0);
        wr_end = 1'b1; end_crc_ok = 1'b1; end_xfer_done = 1'b1; end_bytes = 11'd0;
        tick();
        wr_end = 1'b0;
        // 112 used, 16 free: refused
        wr_start = 1'b1; wr_ep = 4'd14; wr_pid = 2'd0;
        tick();
        wr_start = 1'b0;
        chk("R4", {31'd0, no_space}, 32'd1);
        wr_valid = 1'b1; wr_data = 32'hBAD0_0000;
        tick();
        wr_valid = 1'b0;
        chk("R4", {31'd0, no_space}, 32'd0);
        wr_end = 1'b1; end_crc_ok = 1'b1; end_bytes = 11'd4;
        tick();
        wr_end = 1'b0;
        for (int k = 0; k < 6; k++) recv("R4", 4'd12, 2'd0, 11'd64, 1'b0);
        recv("R4", 4'd12, 2'd0, 11'd32, 1'b0);
        recv("R4", 4'd13, 2'd1, 11'd0, 1'b1);
        chk("R4", {31'd0, rd_valid}, 32'd0);

        // R8: flush with committed data and an open packet
        send(4'd1, 2'd0, 11'd8, 1'b1, 1'b0, 2);
        wr_start = 1'b1; wr_ep = 4'd2;
        tick();
        wr_start = 1'b0;
        wr_valid = 1'b1; wr_data = 32'h1234_5678;
        tick();
        wr_valid = 1'b0;
        flush = 1'b1;
        tick();
        flush = 1'b0;
        chk("R8", {31'd0, rd_valid}, 32'd0);
        chk("R8", {31'd0, rd_sop}, 32'd1);
        wr_end = 1'b1; end_crc_ok = 1'b1; end_bytes = 11'd4;
        tick();
        wr_end = 1'b0;
        tick();
        chk("R8", {31'd0, rd_valid}, 32'd0);
        send(4'd3, 2'd3, 11'd5, 1'b1, 1'b1, 2);
        recv("R8", 4'd3, 2'd3, 11'd5, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule